// File: doc/BRIEF.md
# Wakeup Interrupt Status Aggregator

This block gathers wakeup events for an embedded 8-bit microcontroller. Each event input sets a bit in one of six 8-bit status banks. The bit stays set until firmware writes a one to that position. Any set bit pulls the active-low wake request low. The same condition also feeds the active-low external interrupt 1 request, together with seven other interrupt sources. An 8-bit mask register gates that second line.

Firmware reaches the status banks and the mask through a simple synchronous register port. The port has an address, write data, a write enable, a read enable and read data. A write to a status bank clears the positions written as one and leaves the others alone. Read data is registered and appears the cycle after the read strobe. In the first bank, positions 1 and 2 are reserved. They never latch, they ignore writes and they always read zero.

Top module: `wakeup_irq_agg`

## Requirements
- R1: After reset every status bank and the mask read 0x00, rdData is 0x00, and both int1N and wakeN are high.
- R2: A wakeEvt bit that is 1 at a clock edge sets its status bit from the next cycle on. The bit stays set after the input returns to 0. Bank k holds wakeEvt[8k+7:8k].
- R3: A write to a status bank clears each bit whose wrData bit is 1 and leaves each bit whose wrData bit is 0 unchanged.
- R4: When an event and a write-one clear hit the same bit at the same edge, the event wins and the bit stays set.
- R5: Bits 1 and 2 of bank 0 are reserved. They never set, whether from events or from writes, and they always read 0.
- R6: Bank k sits at address 0x7F2A+k (k = 0..5) and the mask sits at 0x7F03. A read of any other address returns 0x00. rdData updates only on the clock edge where rdEn is 1.
- R7: wakeN is low exactly while at least one status bit is set. The mask does not affect it.
- R8: The mask register is readable and writable in all 8 bits. A mask bit of 0 enables its source.
- R9: int1N is low when any status bit is set and mask bit 7 is 0. It is also low when int1Src[i] is 1 and mask bit i is 0, for any i in 0..6.
- R10: int1N stays high while every active source has its mask bit set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| wakeEvt | input | 48 | Wakeup event inputs, 8 per bank |
| int1Src | input | 7 | Other interrupt 1 sources, one per mask bit 0..6 |
| int1N | output | 1 | Active-low external interrupt 1 request |
| wakeN | output | 1 | Active-low wake request |

## Verification
The hardest case to reach from the ports is a write-one clear that lands on the same edge as a new event for the same bit. Stimulus forces this by driving the event input and the clearing write in the same cycle. The same write also clears a different, already-set bit that has no event, so the outcome shows both that the event wins and that the plain clear still works. The bench also walks the mask through states where the only active cause of int1N is the aggregated wake condition, and then states where the only active cause is a side source. This separates the two paths into the interrupt.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int NBANK = 6;
  localparam int REGW  = 8;
  localparam int SRCW  = REGW - 1;

  typedef struct packed {
    logic [NBANK-1:0] statWr;
    logic             maskWr;
    logic [NBANK-1:0] statSel;
    logic             maskSel;
    logic             rdStb;
  } wkStrobe_t;
endpackage

// File: rtl/wk_ctrl.sv
module wk_ctrl
  import wk_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_BASE = 16'h7F2A,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h7F03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output wkStrobe_t         stb
);
  logic [NBANK-1:0] hitStat;
  logic             hitMask;

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign hitStat[b] = (addr == STAT_BASE + ADDR_W'(b));
  end
  assign hitMask = (addr == MASK_ADDR);

  always_comb begin
    stb.statWr  = wrEn ? hitStat : '0;
    stb.maskWr  = wrEn & hitMask;
    stb.statSel = hitStat;
    stb.maskSel = hitMask;
    stb.rdStb   = rdEn;
  end

  // R6: one register at most is selected for a write
  a_r6_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.statWr, stb.maskWr}));
  // R3: no status write strobe without a bus write
  a_r3_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (stb.statWr == '0 && !stb.maskWr));
endmodule

// File: rtl/wk_datapath.sv
module wk_datapath
  import wk_pkg::*;
#(
  parameter logic [NBANK*REGW-1:0] RSVD = 48'h0000_0000_0006
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wkStrobe_t             stb,
  input  logic [REGW-1:0]       wrData,
  input  logic [NBANK*REGW-1:0] wakeEvt,
  input  logic [SRCW-1:0]       int1Src,
  output logic [REGW-1:0]       rdData,
  output logic                  int1N,
  output logic                  wakeN
);
  localparam int FLATW = NBANK * REGW;

  logic [FLATW-1:0] statQ, clrFlat, evtEff;
  logic [REGW-1:0]  maskQ, rdMux, rdQ;
  logic             anyWake;

  assign evtEff = wakeEvt & ~RSVD;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign clrFlat[b*REGW +: REGW] = stb.statWr[b] ? wrData : '0;
    always_ff @(posedge clk) begin
      if (!rstN) statQ[b*REGW +: REGW] <= '0;
      else statQ[b*REGW +: REGW] <=
        ((statQ[b*REGW +: REGW] & ~clrFlat[b*REGW +: REGW])
         | evtEff[b*REGW +: REGW]) & ~RSVD[b*REGW +: REGW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '0;
    else if (stb.maskWr) maskQ <= wrData;
  end

  always_comb begin
    rdMux = '0;
    for (int b = 0; b < NBANK; b++)
      if (stb.statSel[b]) rdMux = rdMux | statQ[b*REGW +: REGW];
    if (stb.maskSel) rdMux = rdMux | maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdQ <= '0;
    else if (stb.rdStb) rdQ <= rdMux;
  end
  assign rdData = rdQ;

  assign anyWake = |statQ;
  assign wakeN   = ~anyWake;
  assign int1N   = ~((anyWake & ~maskQ[REGW-1]) | (|(int1Src & ~maskQ[SRCW-1:0])));

  // R2 / R4: an accepted event is set next cycle, even against a clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((statQ & $past(evtEff)) == $past(evtEff)));
  // R3: a cleared bit without an event drops
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((statQ & $past(clrFlat & ~evtEff)) == '0));
  // R2: set bits persist unless cleared
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (($past(statQ) & ~$past(clrFlat) & ~statQ) == '0));
  // R5: reserved positions never hold a one
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statQ & RSVD) == '0);
  // R8: mask takes the written value
  a_r8_mask_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.maskWr |=> (maskQ == $past(wrData)));
  // R6: unmapped read returns zero
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb && stb.statSel == '0 && !stb.maskSel) |=> (rdData == '0));
endmodule

// File: rtl/wakeup_irq_agg.sv
module wakeup_irq_agg
  import wk_pkg::*;
#(
  parameter int                    ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]     STAT_BASE = 16'h7F2A,
  parameter logic [ADDR_W-1:0]     MASK_ADDR = 16'h7F03,
  parameter logic [NBANK*REGW-1:0] RSVD      = 48'h0000_0000_0006
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [REGW-1:0]       wrData,
  input  logic                  wrEn,
  input  logic                  rdEn,
  output logic [REGW-1:0]       rdData,
  input  logic [NBANK*REGW-1:0] wakeEvt,
  input  logic [SRCW-1:0]       int1Src,
  output logic                  int1N,
  output logic                  wakeN
);
  wkStrobe_t stb;

  wk_ctrl #(.ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE), .MASK_ADDR(MASK_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb));

  wk_datapath #(.RSVD(RSVD)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .wakeEvt(wakeEvt),
    .int1Src(int1Src), .rdData(rdData), .int1N(int1N), .wakeN(wakeN));
endmodule

// File: tb/sim_wakeup_irq_agg.sv
module sim_wakeup_irq_agg;
  logic        clk = 0, rstN = 0, wrEn = 0, rdEn = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wrData = 0, rdData;
  logic [47:0] wakeEvt = 0;
  logic [6:0]  int1Src = 0;
  logic        int1N, wakeN;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  wakeup_irq_agg u0 (.clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .wakeEvt(wakeEvt),
    .int1Src(int1Src), .int1N(int1N), .wakeN(wakeN));

  // {bank[3:0], event[7:0], clear[7:0], expected[7:0]}
  localparam logic [27:0] VEC [8] = '{
    {4'd0, 8'hFF, 8'h00, 8'hF9}, {4'd0, 8'h81, 8'h01, 8'h80},
    {4'd1, 8'hA5, 8'h0F, 8'hA0}, {4'd2, 8'h3C, 8'h00, 8'h3C},
    {4'd3, 8'hFF, 8'hAA, 8'h55}, {4'd4, 8'h01, 8'h02, 8'h01},
    {4'd5, 8'hF0, 8'hF0, 8'h00}, {4'd5, 8'h66, 8'h00, 8'h66}};

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1; tick(); wrEn = 0;
  endtask
  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    addr = a; rdEn = 1; tick(); rdEn = 0; d = rdData;
  endtask
  task automatic pulse(input int bank, input logic [7:0] e);
    wakeEvt[bank*8 +: 8] = e; tick(); wakeEvt = '0;
  endtask
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); rstN = 1; tick();
    // R1 reset state
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 int1N", {7'd0, int1N}, 8'h01);
    chk("R1 wakeN", {7'd0, wakeN}, 8'h01);
    for (int b = 0; b < 6; b++) begin
      rd(16'h7F2A + 16'(b), v); chk("R1 bank", v, 8'h00);
    end
    rd(16'h7F03, v); chk("R1 mask", v, 8'h00);

    // table walk: R2 R3 R5 R6
    for (int i = 0; i < 8; i++) begin
      pulse(int'(VEC[i][27:24]), VEC[i][23:16]);
      wr(16'h7F2A + 16'(VEC[i][27:24]), VEC[i][15:8]);
      rd(16'h7F2A + 16'(VEC[i][27:24]), v);
      chk("R2/R3/R5/R6 table", v, VEC[i][7:0]);
      wr(16'h7F2A + 16'(VEC[i][27:24]), 8'hFF);
    end

    // R2 sticky after input drops, several cycles later
    pulse(1, 8'h10); tick(); tick();
    rd(16'h7F2B, v); chk("R2 sticky", v, 8'h10);
    wr(16'h7F2B, 8'h00); rd(16'h7F2B, v); chk("R3 zero write keeps", v, 8'h10);
    wr(16'h7F2B, 8'h10); rd(16'h7F2B, v); chk("R3 clear", v, 8'h00);

    // R4 event and clear on same edge; bit7 cleared plainly
    pulse(0, 8'h80);
    addr = 16'h7F2A; wrData = 8'h81; wrEn = 1; wakeEvt[0] = 1'b1;
    tick(); wrEn = 0; wakeEvt = '0;
    rd(16'h7F2A, v); chk("R4 event wins", v, 8'h01);
    wr(16'h7F2A, 8'hFF);

    // R5 reserved bits ignore writes
    wr(16'h7F2A, 8'h06); rd(16'h7F2A, v); chk("R5 reserved", v, 8'h00);

    // R6 unmapped and rdData hold
    pulse(3, 8'h42);
    rd(16'h7F30, v); chk("R6 unmapped", v, 8'h00);
    rd(16'h7F2D, v); addr = 16'h7F03; tick();
    chk("R6 hold without rdEn", rdData, 8'h42);
    wr(16'h7F2D, 8'hFF);

    // R8 mask read/write
    wr(16'h7F03, 8'hA5); rd(16'h7F03, v); chk("R8 mask rw", v, 8'hA5);
    wr(16'h7F03, 8'h00);

    // R7 R9 R10 interrupt lines
    chk("R7 idle wakeN", {7'd0, wakeN}, 8'h01);
    pulse(2, 8'h08);
    chk("R7 wakeN low", {7'd0, wakeN}, 8'h00);
    chk("R9 int1N from wake", {7'd0, int1N}, 8'h00);
    wr(16'h7F03, 8'h80);
    chk("R10 int1N masked", {7'd0, int1N}, 8'h01);
    chk("R7 wakeN unmasked", {7'd0, wakeN}, 8'h00);
    int1Src = 7'h04; #1;
    chk("R9 int1N from side source", {7'd0, int1N}, 8'h00);
    wr(16'h7F03, 8'h84);
    chk("R10 all masked", {7'd0, int1N}, 8'h01);
    wr(16'h7F2C, 8'h08);
    chk("R7 wakeN released", {7'd0, wakeN}, 8'h01);
    int1Src = 7'h00; wr(16'h7F03, 8'h00);
    chk("R10 idle int1N", {7'd0, int1N}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule